// File: doc/BRIEF.md
# Circular Return Address Stack

This block keeps the return addresses of a small processor whose program counter is 12 bits wide. When a subroutine call or an interrupt branch happens, the control logic asserts the push input together with the address to come back to. When a return-with-literal instruction executes, it asserts the pop input and loads the program counter from the top-of-stack output in that same cycle, because that output follows the internal pointer with no register in between.

The storage lies outside both program memory and data memory. Its pointer cannot be seen or changed by any instruction. With the default two entries the buffer is circular. A third push with no pop in between overwrites the oldest address. A pop on an empty stack just steps the pointer back and exposes whatever the slot holds. There is no overflow flag and no underflow flag. A push and a pop in the same cycle act as a pop followed by a push, so the top entry is replaced.

Top module: `ret_addr_stack`

## Requirements
- R1: A push without a pop stores push_addr, and from the next cycle on tos_addr shows that value.
- R2: tos_addr is combinational from the internal pointer. While pop_en is high, before the clock edge, it already shows the entry that the pop removes.
- R3: A pop without a push moves the pointer back one slot. From the next cycle tos_addr shows the entry that was pushed before the removed one (last in, first out).
- R4: The stack is circular with DEPTH entries (default 2). Push A, push B, push C with no pop in between: C overwrites A. Pops after that show B, then C again, as the pointer wraps.
- R5: A pop on an empty stack raises no error. The pointer wraps backwards and tos_addr shows the unchanged contents of the slot it reaches.
- R6: A push and a pop in the same cycle replace the top entry with push_addr and leave the depth unchanged. A following pop shows the entry that was below the replaced one.
- R7: A synchronous active-high rst sets the pointer to slot 0, so that afterwards tos_addr shows slot DEPTH-1. Stored entries are not cleared. Push and pop are ignored while rst is high.
- R8: With neither push nor pop asserted, tos_addr holds its value.
- R9: All 12 address bits are stored and returned exactly, for every bit pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| push_en | input | 1 | Store push_addr as the new top (call or interrupt branch) |
| push_addr | input | 12 | Return address to store |
| pop_en | input | 1 | Remove the top entry (return instruction) |
| tos_addr | output | 12 | Current top-of-stack address, combinational |

## Verification
Directed sequences come first: back-to-back pushes past capacity, which separates a true ring from a saturating or clamped pointer, and pops right after reset, which separate a wrapping pointer from one that sticks at zero. They also check that reset leaves the stored data in place. Walking-one and walking-zero addresses expose stuck or swapped bits on the data path. Same-cycle push and pop tells a top replacement apart from a plain push or a plain pop. A long pseudo-random sweep over all four push/pop combinations is then compared, cycle by cycle, against an arithmetic ring model, and it also samples the top during a pop to confirm the output does not lag the pointer.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Encoding of the request pair {push, pop}
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  // Pointer width for a ring of the given depth (at least one bit)
  function automatic int ptr_width(input int depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction

  // True when depth is a power of two, so the pointer can wrap naturally
  function automatic bit is_pow2(input int depth);
    return (depth > 0) && ((depth & (depth - 1)) == 0);
  endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int PTR_W = ptr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // ptr_q names the slot the next plain push writes; the top sits one below
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;
  ras_op_e          op;

  generate
    if (is_pow2(DEPTH)) begin : g_wrap_pow2
      assign ptr_inc = ptr_q + 1'b1;
      assign ptr_dec = ptr_q - 1'b1;
    end else begin : g_wrap_cmp
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end
  endgenerate

  always_comb op = ras_op_e'({push_req, pop_req});

  always_comb begin
    ptr_d  = ptr_q;
    wr_idx = ptr_q;
    case (op)
      OP_PUSH: ptr_d = ptr_inc;
      OP_POP:  ptr_d = ptr_dec;
      OP_SWAP: wr_idx = ptr_dec;   // pop then push: rewrite the top slot
      default: ;
    endcase
  end

  assign wr_en  = push_req && !rst;
  assign rd_idx = ptr_dec;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  // No reset on the array: contents survive reset and map onto LUT RAM
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
  end

  assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_en,
  output logic [ADDR_W-1:0] tos_addr
);

  localparam int PTR_W = ras_pkg::ptr_width(DEPTH);

  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;

  ras_ptr #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_en),
    .pop_req  (pop_en),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx)
  );

  ras_store #(
    .DATA_W (ADDR_W),
    .DEPTH  (DEPTH),
    .IDX_W  (PTR_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (push_addr),
    .rd_idx  (rd_idx),
    .rd_data (tos_addr)
  );

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              push_en,
  input logic [ADDR_W-1:0] push_addr,
  input logic              pop_en,
  input logic [ADDR_W-1:0] tos_addr
);

  // Cycles since reset released, saturating, so history depth is legal
  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (rst)                  live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  // R1: plain push becomes the visible top on the next cycle
  p_push_top_r1: assert property (@(posedge clk) disable iff (rst)
    (push_en && !pop_en) |=> (tos_addr == $past(push_addr)));

  // R6: simultaneous push and pop leaves the new value on top
  p_swap_top_r6: assert property (@(posedge clk) disable iff (rst)
    (push_en && pop_en) |=> (tos_addr == $past(push_addr)));

  // R8: no request keeps the top unchanged
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!push_en && !pop_en) |=> $stable(tos_addr));

  // R3: two pushes then a pop exposes the first of the two
  p_lifo_order_r3: assert property (@(posedge clk) disable iff (rst)
    ((live_cnt >= 2'd2) && pop_en && !push_en
      && $past(push_en && !pop_en) && $past(push_en && !pop_en, 2))
    |=> (tos_addr == $past(push_addr, 3)));

endmodule

bind ret_addr_stack ret_addr_stack_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_en   (push_en),
  .push_addr (push_addr),
  .pop_en    (pop_en),
  .tos_addr  (tos_addr)
);

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int D          = 2;
  localparam int WATCHDOG   = 200000;

  logic          clk = 1'b0;
  logic          rst;
  logic          push_en;
  logic          pop_en;
  logic [AW-1:0] push_addr;
  logic [AW-1:0] tos_addr;

  int n_vec = 0;
  int n_bad = 0;

  // Arithmetic ring model built from the requirements
  logic [AW-1:0] m_mem [D];
  int            m_ptr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .DEPTH(D)) u0 (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .push_addr (push_addr),
    .pop_en    (pop_en),
    .tos_addr  (tos_addr)
  );

  function automatic logic [AW-1:0] exp_top();
    return m_mem[(m_ptr + D - 1) % D];
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tos_addr=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at a falling edge, update model at the rising edge,
  // return at the next falling edge with the result settled
  task automatic step(input bit ps, input bit pp, input logic [AW-1:0] a,
                      input bit r);
    push_en   = ps;
    pop_en    = pp;
    push_addr = a;
    rst       = r;
    #1;
    if (pp && !ps && !r) chk("R2", tos_addr, exp_top());
    @(posedge clk);
    if (r) m_ptr = 0;
    else if (ps && pp) m_mem[(m_ptr + D - 1) % D] = a;
    else if (ps) begin
      m_mem[m_ptr] = a;
      m_ptr = (m_ptr + 1) % D;
    end else if (pp) m_ptr = (m_ptr + D - 1) % D;
    @(negedge clk);
    push_en = 1'b0;
    pop_en  = 1'b0;
    rst     = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; push_en = 1'b0; pop_en = 1'b0; push_addr = '0;
    @(negedge clk);
    step(0, 0, '0, 1);
    step(0, 0, '0, 1);

    // R1: fill both slots
    step(1, 0, 12'h111, 0); chk("R1", tos_addr, 12'h111);
    step(1, 0, 12'h222, 0); chk("R1", tos_addr, 12'h222);

    // R7: reset with push and pop held high; pointer to slot 0, data kept
    step(1, 1, 12'hABC, 1);
    step(1, 1, 12'hABC, 1);
    chk("R7", tos_addr, 12'h222);
    step(0, 1, '0, 0);
    chk("R7", tos_addr, 12'h111);   // slot 0 untouched by reset-time push

    // R5: keep popping past empty, pointer wraps
    step(0, 1, '0, 0); chk("R5", tos_addr, 12'h222);
    step(0, 1, '0, 0); chk("R5", tos_addr, 12'h111);

    // R4: three pushes overwrite the oldest, pops wrap
    step(0, 0, '0, 1);
    step(1, 0, 12'h00A, 0); chk("R4", tos_addr, 12'h00A);
    step(1, 0, 12'h00B, 0); chk("R4", tos_addr, 12'h00B);
    step(1, 0, 12'h00C, 0); chk("R4", tos_addr, 12'h00C);
    step(0, 1, '0, 0);      chk("R4", tos_addr, 12'h00B);
    step(0, 1, '0, 0);      chk("R4", tos_addr, 12'h00C);

    // R3: LIFO order
    step(1, 0, 12'h5A5, 0);
    step(1, 0, 12'hA5A, 0);
    step(0, 1, '0, 0);      chk("R3", tos_addr, 12'h5A5);

    // R6: same-cycle push and pop replace the top, the entry below survives
    step(1, 0, 12'h700, 0);
    step(1, 0, 12'h701, 0);
    step(1, 1, 12'h7FF, 0); chk("R6", tos_addr, 12'h7FF);
    step(0, 1, '0, 0);      chk("R6", tos_addr, 12'h700);

    // R8: idle cycles hold the top
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 12'hFFF, 0); chk("R8", tos_addr, exp_top());
    end

    // R9: walking ones and walking zeros through every bit
    for (int b = 0; b < AW; b++) begin
      step(1, 0, AW'(1) << b, 0);    chk("R9", tos_addr, AW'(1) << b);
      step(1, 0, ~(AW'(1) << b), 0); chk("R9", tos_addr, ~(AW'(1) << b));
      step(0, 1, '0, 0);             chk("R9", tos_addr, AW'(1) << b);
    end

    // Sweep all four request combinations against the ring model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1], lfsr[0], lfsr[13:2], 0);
      case (lfsr[1:0])
        2'b00:   chk("R8", tos_addr, exp_top());
        2'b01:   chk("R3", tos_addr, exp_top());
        2'b10:   chk("R1", tos_addr, exp_top());
        default: chk("R6", tos_addr, exp_top());
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule